// File: doc/BRIEF.md
# Serial Word Receiver and Formatter

This block receives words from a synchronous serial line that carries a bit clock, a frame-sync strobe and one data wire. The bit clock is oversampled by the system clock. A frame-sync seen high on a rising bit-clock edge opens a word, and the next N rising edges each deliver one data bit. The word length N, the bit order, the fill rule for the unused upper bits and the pairing of two 16-bit words into one 32-bit result all come from control inputs. These inputs are captured when the word opens, so changing them while a word is being shifted in has no effect on that word.

Each finished word is placed right-justified in a 32-bit result. The bits above the word are either zero or copies of the word's top bit, depending on the selected type code. The result is offered on a valid/ready output. Two line modes exist. The general serial mode honours the bit-order control and accepts words of 3 to 32 bits. The audio-style mode always takes the MSB first and accepts words of 8 to 32 bits. Three sticky flags report the following events: a length request below the mode minimum, a request for a companded type (which this block does not expand), and a result that was overwritten before it was taken.

Top module: `ser_word_rx`

## Requirements
- R1: With type code 00, the word length is the 5-bit length field plus one. The received word sits in bits N-1..0 of `out_data`, and all bits above it read zero.
- R2: With type code 01, the bits above the word are copies of the word's top received bit (bit N-1).
- R3: In general serial mode (`cfg_i2s`=0), `cfg_lsb_first`=1 means the first bit on the line is bit 0 of the word. With 0, the first bit is bit N-1.
- R4: In audio-style mode (`cfg_i2s`=1), `cfg_lsb_first` is ignored and the first bit on the line is always bit N-1.
- R5: A length field below the mode minimum (2 in general mode, 7 in audio-style mode) is raised to that minimum, giving 3 or 8 bits. The field is checked when the word opens, and when it is raised `err_len` is set. `err_len` stays set until reset.
- R6: Type codes 10 and 11 both set the sticky flag `err_unsup` when the word completes. The word is still delivered, zero-filled as for code 00.
- R7: With `cfg_pack`=1, the low 16 bits of the first word go to `out_data[31:16]` and the low 16 bits of the second word go to `out_data[15:0]`. `out_valid` rises only after the second word.
- R8: While `cfg_en`=0, no bit is captured and no result is produced. A word that is partly received when `cfg_en` falls is discarded.
- R9: A word opens on a rising bit-clock edge that samples frame-sync high. Its bits are taken on the following N rising edges. The control inputs are captured at the opening edge.
- R10: `out_valid` and `out_data` hold until `out_ready` is seen high. If a new result is ready while the old one is still held, the new one replaces it and the sticky flag `err_ovf` is set.
- R11: After reset, `out_valid` and all three error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| fsync | input | 1 | Frame-sync strobe; opens a word |
| sdata | input | 1 | Serial data line |
| cfg_en | input | 1 | Receive enable |
| cfg_i2s | input | 1 | 0 = general serial mode, 1 = audio-style mode |
| cfg_lsb_first | input | 1 | 1 = LSB arrives first (general serial mode only) |
| cfg_dtype | input | 2 | 00 zero-fill, 01 sign-extend, 10/11 companded (flagged, zero-filled) |
| cfg_len_field | input | 5 | Word length minus one |
| cfg_pack | input | 1 | Pair two 16-bit words into one 32-bit result |
| out_data | output | 32 | Formatted result |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| err_len | output | 1 | Sticky: a length field was raised to the mode minimum |
| err_unsup | output | 1 | Sticky: a companded type code was used |
| err_ovf | output | 1 | Sticky: a held result was overwritten |

## Verification
A bit counter or captured length that is off by one shifts the whole word by one place. This shows up on the first result after the fault as a doubled or halved value, or as a stray bit in the fill region. A fault in the bit-order or fill choice corrupts the upper bits of that same result, which is why the test words use asymmetric patterns and set top bits. Faults in pairing, enable gating or overwrite handling show up as a result that is missing, extra or out of order on the valid/ready output. The scoreboard reports these at the handshake, or the final queue check reports them at the end of the run.

// File: rtl/ser_word_rx_pkg.sv
package ser_word_rx_pkg;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    // type code values
    localparam logic [1:0] DT_ZERO_FILL = 2'b00;
    localparam logic [1:0] DT_SIGN_EXT  = 2'b01;

endpackage

// File: rtl/ser_bit_sampler.sv
module ser_bit_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic fsync,
    input  logic sdata,
    output logic bit_stb,
    output logic fs_smp,
    output logic dat_smp
);

    typedef struct packed {
        logic clk_now;
        logic clk_old;
        logic fs;
        logic dat;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d         = smp_q;
        smp_d.clk_now = ser_clk;
        smp_d.clk_old = smp_q.clk_now;
        smp_d.fs      = fsync;
        smp_d.dat     = sdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    // one strobe per rising bit-clock edge; line values taken in the same sample
    assign bit_stb = smp_q.clk_now & ~smp_q.clk_old;
    assign fs_smp  = smp_q.fs;
    assign dat_smp = smp_q.dat;

endmodule

// File: rtl/ser_deframer.sv
module ser_deframer
    import ser_word_rx_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 5,
    parameter int DSP_MIN_LEN = 3,
    parameter int I2S_MIN_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              fs_smp,
    input  logic              dat_smp,
    input  logic              cfg_en,
    input  logic              cfg_i2s,
    input  logic              cfg_lsb_first,
    input  logic [1:0]        cfg_dtype,
    input  logic [LEN_W-1:0]  cfg_len_field,
    input  logic              cfg_pack,
    output logic              word_done,
    output logic [DATA_W-1:0] word_raw,
    output logic [LEN_W-1:0]  word_len_m1,
    output logic [1:0]        word_dtype,
    output logic              word_pack,
    output logic              len_clamp_evt
);

    localparam logic [LEN_W-1:0] DSP_MIN_M1 = LEN_W'(DSP_MIN_LEN - 1);
    localparam logic [LEN_W-1:0] I2S_MIN_M1 = LEN_W'(I2S_MIN_LEN - 1);

    typedef struct packed {
        rx_state_e          st;
        logic [LEN_W-1:0]   cnt;
        logic [DATA_W-1:0]  acc;
        logic [LEN_W-1:0]   len_m1;
        logic               lsb;
        logic [1:0]         dtype;
        logic               pack;
        logic               done;
        logic [DATA_W-1:0]  o_word;
        logic [LEN_W-1:0]   o_len_m1;
        logic [1:0]         o_dtype;
        logic               o_pack;
        logic               clamp;
    } dfr_t;

    dfr_t dfr_d, dfr_q;

    logic [LEN_W-1:0]  min_m1;
    logic [DATA_W-1:0] nxt_acc;
    logic              last_bit;

    always_comb begin
        min_m1   = cfg_i2s ? I2S_MIN_M1 : DSP_MIN_M1;
        nxt_acc  = dfr_q.lsb
                 ? (dfr_q.acc | ({{(DATA_W-1){1'b0}}, dat_smp} << dfr_q.cnt))
                 : {dfr_q.acc[DATA_W-2:0], dat_smp};
        last_bit = (dfr_q.cnt == dfr_q.len_m1);

        dfr_d       = dfr_q;
        dfr_d.done  = 1'b0;
        dfr_d.clamp = 1'b0;

        if (!cfg_en) begin
            dfr_d.st  = RX_IDLE;
            dfr_d.cnt = '0;
        end else if (bit_stb) begin
            if (dfr_q.st == RX_SHIFT) begin
                dfr_d.acc = nxt_acc;
                if (last_bit) begin
                    dfr_d.done     = 1'b1;
                    dfr_d.o_word   = nxt_acc;
                    dfr_d.o_len_m1 = dfr_q.len_m1;
                    dfr_d.o_dtype  = dfr_q.dtype;
                    dfr_d.o_pack   = dfr_q.pack;
                    dfr_d.st       = RX_IDLE;
                    dfr_d.cnt      = '0;
                end else begin
                    dfr_d.cnt = dfr_q.cnt + 1'b1;
                end
            end
            // a frame sync opens a word when idle or on a word's final edge
            if (fs_smp && (dfr_q.st == RX_IDLE || last_bit)) begin
                dfr_d.st     = RX_SHIFT;
                dfr_d.cnt    = '0;
                dfr_d.acc    = '0;
                dfr_d.lsb    = cfg_lsb_first & ~cfg_i2s;
                dfr_d.dtype  = cfg_dtype;
                dfr_d.pack   = cfg_pack;
                if (cfg_len_field < min_m1) begin
                    dfr_d.len_m1 = min_m1;
                    dfr_d.clamp  = 1'b1;
                end else begin
                    dfr_d.len_m1 = cfg_len_field;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dfr_q <= '0;
        else        dfr_q <= dfr_d;
    end

    assign word_done     = dfr_q.done;
    assign word_raw      = dfr_q.o_word;
    assign word_len_m1   = dfr_q.o_len_m1;
    assign word_dtype    = dfr_q.o_dtype;
    assign word_pack     = dfr_q.o_pack;
    assign len_clamp_evt = dfr_q.clamp;

endmodule

// File: rtl/ser_formatter.sv
module ser_formatter
    import ser_word_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [1:0]        dtype,
    output logic [DATA_W-1:0] fmt,
    output logic              unsup
);

    logic top_bit;
    logic fill_bit;

    always_comb begin
        unsup    = dtype[1];
        top_bit  = raw[len_m1];
        fill_bit = (dtype == DT_SIGN_EXT) ? top_bit : 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fmt[i] = (i <= int'(len_m1)) ? raw[i] : fill_bit;
        end
    end

endmodule

// File: rtl/ser_out_stage.sv
module ser_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              in_stb,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_pack,
    input  logic              in_unsup,
    input  logic              len_clamp_evt,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err_len,
    output logic              err_unsup,
    output logic              err_ovf
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              half_vld;
        logic [HALF_W-1:0] half;
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              f_len;
        logic              f_uns;
        logic              f_ovf;
    } ost_t;

    ost_t ost_d, ost_q;

    logic              emit;
    logic [DATA_W-1:0] emit_word;

    always_comb begin
        ost_d     = ost_q;
        emit      = 1'b0;
        emit_word = in_word;

        if (ost_q.vld && out_ready) ost_d.vld = 1'b0;

        if (!cfg_en) ost_d.half_vld = 1'b0;

        if (in_stb) begin
            if (in_pack) begin
                if (!ost_q.half_vld) begin
                    ost_d.half     = in_word[HALF_W-1:0];
                    ost_d.half_vld = 1'b1;
                end else begin
                    emit           = 1'b1;
                    emit_word      = {ost_q.half, in_word[HALF_W-1:0]};
                    ost_d.half_vld = 1'b0;
                end
            end else begin
                emit           = 1'b1;
                ost_d.half_vld = 1'b0;
            end
            if (in_unsup) ost_d.f_uns = 1'b1;
        end

        if (emit) begin
            if (ost_q.vld && !out_ready) ost_d.f_ovf = 1'b1;
            ost_d.data = emit_word;
            ost_d.vld  = 1'b1;
        end

        if (len_clamp_evt) ost_d.f_len = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ost_q <= '0;
        else        ost_q <= ost_d;
    end

    assign out_data  = ost_q.data;
    assign out_valid = ost_q.vld;
    assign err_len   = ost_q.f_len;
    assign err_unsup = ost_q.f_uns;
    assign err_ovf   = ost_q.f_ovf;

endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx #(
    parameter int  DATA_W      = 32,
    parameter int  DSP_MIN_LEN = 3,
    parameter int  I2S_MIN_LEN = 8,
    localparam int LEN_W       = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              cfg_en,
    input  logic              cfg_i2s,
    input  logic              cfg_lsb_first,
    input  logic [1:0]        cfg_dtype,
    input  logic [LEN_W-1:0]  cfg_len_field,
    input  logic              cfg_pack,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              err_len,
    output logic              err_unsup,
    output logic              err_ovf
);

    logic              bit_stb;
    logic              fs_smp;
    logic              dat_smp;
    logic              w_done;
    logic [DATA_W-1:0] w_raw;
    logic [LEN_W-1:0]  w_len_m1;
    logic [1:0]        w_dtype;
    logic              w_pack;
    logic              w_clamp;
    logic [DATA_W-1:0] w_fmt;
    logic              w_unsup;

    ser_bit_sampler u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .fsync   (fsync),
        .sdata   (sdata),
        .bit_stb (bit_stb),
        .fs_smp  (fs_smp),
        .dat_smp (dat_smp)
    );

    ser_deframer #(
        .DATA_W      (DATA_W),
        .LEN_W       (LEN_W),
        .DSP_MIN_LEN (DSP_MIN_LEN),
        .I2S_MIN_LEN (I2S_MIN_LEN)
    ) u_dfr (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_stb       (bit_stb),
        .fs_smp        (fs_smp),
        .dat_smp       (dat_smp),
        .cfg_en        (cfg_en),
        .cfg_i2s       (cfg_i2s),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_dtype     (cfg_dtype),
        .cfg_len_field (cfg_len_field),
        .cfg_pack      (cfg_pack),
        .word_done     (w_done),
        .word_raw      (w_raw),
        .word_len_m1   (w_len_m1),
        .word_dtype    (w_dtype),
        .word_pack     (w_pack),
        .len_clamp_evt (w_clamp)
    );

    ser_formatter #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_fmt (
        .raw    (w_raw),
        .len_m1 (w_len_m1),
        .dtype  (w_dtype),
        .fmt    (w_fmt),
        .unsup  (w_unsup)
    );

    ser_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_en        (cfg_en),
        .in_stb        (w_done),
        .in_word       (w_fmt),
        .in_pack       (w_pack),
        .in_unsup      (w_unsup),
        .len_clamp_evt (w_clamp),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .err_len       (err_len),
        .err_unsup     (err_unsup),
        .err_ovf       (err_ovf)
    );

endmodule

// File: rtl/ser_word_rx_chk.sv
module ser_word_rx_chk #(
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 5,
    parameter int DSP_MIN_LEN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              err_len,
    input logic              err_unsup,
    input logic              err_ovf,
    input logic              word_done,
    input logic              word_pack,
    input logic [LEN_W-1:0]  word_len_m1
);

    // R10: a held result stays offered until taken
    a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R10: an unpacked word arriving on a held result raises the overwrite flag
    a_r10_overwrite_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && word_done && !word_pack) |=> err_ovf);

    // R10: held data does not change unless a new word arrives
    a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !word_done) |=> $stable(out_data));

    // R10: overwrite flag is sticky
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);

    // R5: length flag is sticky
    a_r5_len_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |=> err_len);

    // R5: no completed word is shorter than the general-mode minimum
    a_r5_len_floor: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (int'(word_len_m1) >= DSP_MIN_LEN - 1));

    // R6: unsupported-type flag is sticky
    a_r6_unsup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_unsup |=> err_unsup);

    // R8: a disabled receiver completes no word
    a_r8_no_word_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !word_done);

endmodule

bind ser_word_rx ser_word_rx_chk #(
    .DATA_W      (DATA_W),
    .LEN_W       (LEN_W),
    .DSP_MIN_LEN (DSP_MIN_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .err_len     (err_len),
    .err_unsup   (err_unsup),
    .err_ovf     (err_ovf),
    .word_done   (w_done),
    .word_pack   (w_pack),
    .word_len_m1 (w_len_m1)
);

// File: tb/tb_ser_word_rx.sv
module tb_ser_word_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_i2s = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_dtype = 2'b00;
    logic [4:0]  cfg_len_field = 5'd15;
    logic        cfg_pack = 1'b0;
    logic [31:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        err_len;
    logic        err_unsup;
    logic        err_ovf;

    always #4 clk = ~clk;   // 125 MHz

    ser_word_rx dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_clk       (ser_clk),
        .fsync         (fsync),
        .sdata         (sdata),
        .cfg_en        (cfg_en),
        .cfg_i2s       (cfg_i2s),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_dtype     (cfg_dtype),
        .cfg_len_field (cfg_len_field),
        .cfg_pack      (cfg_pack),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .err_len       (err_len),
        .err_unsup     (err_unsup),
        .err_ovf       (err_ovf)
    );

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   ended  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: compare every accepted result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk("R8/R10 unexpected output", out_data, 32'hxxxx_xxxx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, out_data, e.val);
            end
        end
    end

    // expected formatting computed from the requirements
    function automatic logic [31:0] fmt_exp(input logic [31:0] v, input int n, input logic [1:0] dt);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (i < n)            r[i] = v[i];
            else if (dt == 2'b01) r[i] = v[n-1];
            else                  r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic bit_slot(input logic fs, input logic d);
        @(posedge clk); #1;
        ser_clk = 1'b0;
        fsync   = fs;
        sdata   = d;
        repeat (4) @(posedge clk);
        #1 ser_clk = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // frame sync slot, then n data slots, then one idle slot
    task automatic send_word(input logic [31:0] v, input int n, input bit lsb_first);
        bit_slot(1'b1, 1'b0);
        for (int i = 0; i < n; i++) begin
            bit_slot(1'b0, lsb_first ? v[i] : v[n-1-i]);
        end
        bit_slot(1'b0, 1'b0);
        repeat (6) @(posedge clk);
    endtask

    task automatic push(input logic [31:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        chk("R11 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R11 flags", {29'd0, err_len, err_unsup, err_ovf}, 32'd0);
        @(posedge clk); #1;
        rst_n  = 1'b1;
        cfg_en = 1'b1;
        repeat (4) @(posedge clk);

        // R1 / R9: zero-filled, MSB first, several lengths
        cfg_dtype = 2'b00; cfg_len_field = 5'd15;
        push(32'h0000_BEEF, "R1 len16");
        send_word(32'h0000_BEEF, 16, 0);
        cfg_len_field = 5'd31;
        push(32'hDEAD_BEEF, "R1 len32");
        send_word(32'hDEAD_BEEF, 32, 0);
        cfg_len_field = 5'd2;
        push(32'd5, "R1 len3");
        send_word(32'd5, 3, 0);
        cfg_len_field = 5'd11;
        push(32'h0000_09A5, "R1 len12 zero-fill");
        send_word(32'h9A5, 12, 0);

        // R2: sign extension from bit N-1
        cfg_dtype = 2'b01;
        push(fmt_exp(32'h9A5, 12, 2'b01), "R2 negative");
        send_word(32'h9A5, 12, 0);
        push(fmt_exp(32'h5A5, 12, 2'b01), "R2 positive");
        send_word(32'h5A5, 12, 0);

        // R3: LSB first in general mode
        cfg_dtype = 2'b00; cfg_lsb_first = 1'b1; cfg_len_field = 5'd9;
        push(32'h0000_02C3, "R3 lsb first");
        send_word(32'h2C3, 10, 1);

        @(negedge clk);
        chk("R5/R6/R10 no spurious flags", {29'd0, err_len, err_unsup, err_ovf}, 32'd0);

        // R4: audio-style mode ignores bit order
        cfg_i2s = 1'b1; cfg_len_field = 5'd15;
        push(32'h0000_1234, "R4 msb forced");
        send_word(32'h1234, 16, 0);

        // R5: clamp in audio-style mode to 8 bits
        cfg_len_field = 5'd3;
        push(32'h0000_00A7, "R5 clamp to 8");
        send_word(32'hA7, 8, 0);
        @(negedge clk);
        chk("R5 err_len set", {31'd0, err_len}, 32'd1);

        // R5: clamp in general mode to 3 bits
        cfg_i2s = 1'b0; cfg_lsb_first = 1'b0; cfg_len_field = 5'd0;
        push(32'd6, "R5 clamp to 3");
        send_word(32'd6, 3, 0);

        // R6: companded codes flagged, zero-filled
        cfg_len_field = 5'd7; cfg_dtype = 2'b11;
        push(32'h0000_0095, "R6 code 11 zero-fill");
        send_word(32'h95, 8, 0);
        @(negedge clk);
        chk("R6 err_unsup set", {31'd0, err_unsup}, 32'd1);
        cfg_dtype = 2'b10;
        push(32'h0000_00C1, "R6 code 10 zero-fill");
        send_word(32'hC1, 8, 0);

        // R7: pairing of two 16-bit words
        cfg_dtype = 2'b00; cfg_len_field = 5'd15; cfg_pack = 1'b1;
        send_word(32'h1234, 16, 0);
        @(negedge clk);
        chk("R7 no output after first half", {31'd0, out_valid}, 32'd0);
        push(32'h1234_ABCD, "R7 packed");
        send_word(32'hABCD, 16, 0);
        cfg_pack = 1'b0;

        // R8: disabled receiver ignores the line
        cfg_en = 1'b0;
        send_word(32'hFFFF, 16, 0);
        @(negedge clk);
        chk("R8 no output when off", {31'd0, out_valid}, 32'd0);
        @(posedge clk); #1;
        cfg_en = 1'b1;
        push(32'h0000_3C5A, "R8 after re-enable");
        send_word(32'h3C5A, 16, 0);

        // R10: hold and overwrite
        cfg_len_field = 5'd7;
        @(posedge clk); #1;
        out_ready = 1'b0;
        send_word(32'h11, 8, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 held valid", {31'd0, out_valid}, 32'd1);
        chk("R10 held data", out_data, 32'h11);
        chk("R10 no overflow yet", {31'd0, err_ovf}, 32'd0);
        send_word(32'h22, 8, 0);
        @(negedge clk);
        chk("R10 overwritten data", out_data, 32'h22);
        chk("R10 err_ovf set", {31'd0, err_ovf}, 32'd1);
        push(32'h22, "R10 drained");
        @(posedge clk); #1;
        out_ready = 1'b1;
        repeat (6) @(posedge clk);

        @(negedge clk);
        chk("R10 all results seen", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule